// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block runs in the pixel clock domain and produces the raster timing for a display. Two counters, one for pixels along a line and one for lines within a frame, each step through four phases: sync, back porch, active data and front porch. The length of every phase comes from its own programmable width input. While both counters are in their active phase, the block takes one pixel from an upstream pixel FIFO and drives it out with a data-enable strobe.

The block reports four single-cycle events: the start of vertical sync, the end of vertical sync, the end of a frame, and a FIFO underrun. If the FIFO is empty when a pixel is due, the block raises the underrun event. It then holds the last good pixel for the rest of the frame and stops reading the FIFO until the next frame starts. Each of the five outputs with a polarity (vertical sync, horizontal sync, data enable, pixel data and the pixel-clock edge select) has its own inversion bit. Width and polarity inputs are expected to stay static while the block is enabled.

Top module: `disp_timing_gen`

## Requirements
- R1: While reset or `enable` is low, every output sits at its inactive level: sync and data-enable equal their polarity bits, `pixelOut` is all copies of polarity bit 3, `pxlEdgeSel` is 0, and there are no events and no pops. Each enable starts from the first cycle of a frame.
- R2: Each line runs sync, back porch, active and front porch in that order. A width value N gives N+1 pixel cycles in that phase. Horizontal sync is raw-active during the first `hSyncW`+1 cycles of a line.
- R3: Each frame runs the same four phases in lines, with N+1 lines per phase. Vertical sync is raw-active for the first `vSyncW`+1 lines.
- R4: Data enable is raw-active exactly when both the line and the frame position are in their active phase.
- R5: In an active position cycle where the FIFO is not empty and no repeat is pending, `fifoPop` is high in that same cycle (combinational). The popped `fifoData` appears on `pixelOut` one cycle later. Outside active positions, the raw pixel output is zero.
- R6: An empty FIFO at an active position raises `evUnderrun` for one cycle, at most once per frame. For the rest of that frame, `fifoPop` stays low and every active pixel repeats the last popped value, or zero if nothing has been popped since enable.
- R7: The repeat state clears at the first cycle of the next frame, and normal popping resumes.
- R8: `evVsyncBegin` marks the first cycle of a frame. `evVsyncEnd` marks the last cycle of the last sync line. `evFrameDone` marks the last cycle of the frame. Each event and every other output appears one cycle after the position it describes.
- R9: Polarity bit 0 inverts vertical sync, bit 1 horizontal sync, bit 2 data enable, and bit 3 every pixel data bit. While enabled, `pxlEdgeSel` equals bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the timing generator |
| hSyncW | input | CNT_W | Horizontal sync width minus one |
| hBackW | input | CNT_W | Horizontal back porch width minus one |
| hActW | input | CNT_W | Horizontal active width minus one |
| hFrontW | input | CNT_W | Horizontal front porch width minus one |
| vSyncW | input | CNT_W | Vertical sync lines minus one |
| vBackW | input | CNT_W | Vertical back porch lines minus one |
| vActW | input | CNT_W | Vertical active lines minus one |
| vFrontW | input | CNT_W | Vertical front porch lines minus one |
| polarity | input | 5 | Per-output inversion bits |
| fifoEmpty | input | 1 | Pixel FIFO has no data |
| fifoData | input | PIX_W | Pixel at the FIFO head |
| fifoPop | output | 1 | Take the FIFO head this cycle |
| hSyncOut | output | 1 | Horizontal sync |
| vSyncOut | output | 1 | Vertical sync |
| dataEnOut | output | 1 | Data enable |
| pixelOut | output | PIX_W | Pixel data |
| pxlEdgeSel | output | 1 | Pixel clock edge select |
| evVsyncBegin | output | 1 | Vertical sync start event |
| evVsyncEnd | output | 1 | Vertical sync end event |
| evFrameDone | output | 1 | Frame end event |
| evUnderrun | output | 1 | FIFO underrun event |

## Verification
Underrun detection and the pixel hold happen in the same cycle: the empty flag is sampled exactly when an active pixel is due. The bench raises `fifoEmpty` on chosen active positions, including a second empty in the same frame and a periodic pattern that hits every frame. A per-cycle arithmetic model predicts the pop, the event and the repeated pixel value. The model also checks that popping resumes at the next frame start.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  // Strobes passed from control to datapath, one set per pixel cycle
  typedef struct packed {
    logic run;
    logic frameStart;
    logic vsEnd;
    logic frameDone;
    logic active;
    logic hSync;
    logic vSync;
  } ctl_strobe_t;

  localparam int POL_VSYNC = 0;
  localparam int POL_HSYNC = 1;
  localparam int POL_DEN   = 2;
  localparam int POL_DATA  = 3;
  localparam int POL_PCLK  = 4;
  localparam int POL_W     = 5;

  function automatic phase_e nextPhase(phase_e p);
    return phase_e'(p + 2'd1);
  endfunction

endpackage

// File: rtl/disp_axis_counter.sv
module disp_axis_counter
  import disp_timing_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  step,
  input  logic [3:0][CNT_W-1:0] widths,
  output phase_e                phase,
  output logic [CNT_W-1:0]      cnt,
  output logic                  phaseEnd,
  output logic                  axisEnd
);

  logic [CNT_W-1:0] curW;

  always_comb begin
    curW     = widths[phase];
    phaseEnd = run && step && (cnt == curW);
    axisEnd  = phaseEnd && (phase == PH_FRONT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (!run) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (phaseEnd) begin
      phase <= nextPhase(phase);
      cnt   <= '0;
    end else if (step) begin
      cnt   <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= curW)) else $error("count beyond phase width"); // R2

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (phase != $past(phase))) |-> (phase == nextPhase($past(phase))))
    else $error("phase skipped"); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && phase == PH_SYNC)) else $error("counter not idle"); // R1

endmodule

// File: rtl/disp_timing_ctl.sv
module disp_timing_ctl
  import disp_timing_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic [3:0][CNT_W-1:0] hWidths,
  input  logic [3:0][CNT_W-1:0] vWidths,
  output ctl_strobe_t           strobe
);

  phase_e           hPhase, vPhase;
  logic [CNT_W-1:0] hCnt, vCnt;
  logic             hPhaseEnd, lineEnd, vPhaseEnd, frameEnd;

  disp_axis_counter #(.CNT_W(CNT_W)) u_hAxis (
    .clk(clk), .rst_n(rst_n), .run(enable), .step(1'b1), .widths(hWidths),
    .phase(hPhase), .cnt(hCnt), .phaseEnd(hPhaseEnd), .axisEnd(lineEnd)
  );

  disp_axis_counter #(.CNT_W(CNT_W)) u_vAxis (
    .clk(clk), .rst_n(rst_n), .run(enable), .step(lineEnd), .widths(vWidths),
    .phase(vPhase), .cnt(vCnt), .phaseEnd(vPhaseEnd), .axisEnd(frameEnd)
  );

  always_comb begin
    strobe.run        = enable;
    strobe.frameStart = enable && hPhase == PH_SYNC && hCnt == '0 &&
                        vPhase == PH_SYNC && vCnt == '0;
    strobe.vsEnd      = vPhaseEnd && (vPhase == PH_SYNC);
    strobe.frameDone  = frameEnd;
    strobe.active     = enable && hPhase == PH_ACT && vPhase == PH_ACT;
    strobe.hSync      = enable && hPhase == PH_SYNC;
    strobe.vSync      = enable && vPhase == PH_SYNC;
  end

  AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.frameStart, strobe.vsEnd, strobe.frameDone}))
    else $error("frame events overlap"); // R8

  AST_LINE_IN_HFRONT: assert property (@(posedge clk) disable iff (!rst_n)
    lineEnd |-> (hPhase == PH_FRONT && hPhaseEnd)) else $error("line end misplaced"); // R3

endmodule

// File: rtl/disp_timing_dp.sv
module disp_timing_dp
  import disp_timing_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_strobe_t      strobe,
  input  logic [POL_W-1:0] polarity,
  input  logic             fifoEmpty,
  input  logic [PIX_W-1:0] fifoData,
  output logic             fifoPop,
  output logic             hSyncOut,
  output logic             vSyncOut,
  output logic             dataEnOut,
  output logic [PIX_W-1:0] pixelOut,
  output logic             pxlEdgeSel,
  output logic             evVsyncBegin,
  output logic             evVsyncEnd,
  output logic             evFrameDone,
  output logic             evUnderrun
);

  logic             repeatOn, underNow;
  logic [PIX_W-1:0] lastPix, pixQ;
  logic             hsQ, vsQ, denQ, runQ;

  always_comb begin
    fifoPop  = strobe.active && !fifoEmpty && !repeatOn;
    underNow = strobe.active && fifoEmpty && !repeatOn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      repeatOn <= 1'b0;
      lastPix  <= '0;
    end else if (!strobe.run) begin
      repeatOn <= 1'b0;
      lastPix  <= '0;
    end else begin
      if (strobe.frameStart) repeatOn <= 1'b0;
      else if (underNow)     repeatOn <= 1'b1;
      if (fifoPop)           lastPix  <= fifoData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pixQ <= '0; hsQ <= 1'b0; vsQ <= 1'b0; denQ <= 1'b0; runQ <= 1'b0;
      evVsyncBegin <= 1'b0; evVsyncEnd <= 1'b0; evFrameDone <= 1'b0; evUnderrun <= 1'b0;
    end else begin
      pixQ         <= strobe.active ? (fifoPop ? fifoData : lastPix) : '0;
      hsQ          <= strobe.hSync;
      vsQ          <= strobe.vSync;
      denQ         <= strobe.active;
      runQ         <= strobe.run;
      evVsyncBegin <= strobe.frameStart;
      evVsyncEnd   <= strobe.vsEnd;
      evFrameDone  <= strobe.frameDone;
      evUnderrun   <= underNow;
    end
  end

  always_comb begin
    hSyncOut   = hsQ ^ polarity[POL_HSYNC];
    vSyncOut   = vsQ ^ polarity[POL_VSYNC];
    dataEnOut  = denQ ^ polarity[POL_DEN];
    pixelOut   = pixQ ^ {PIX_W{polarity[POL_DATA]}};
    pxlEdgeSel = runQ & polarity[POL_PCLK];
  end

  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifoPop |-> !fifoEmpty) else $error("pop from empty fifo"); // R5

  AST_NO_POP_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    repeatOn |-> !fifoPop) else $error("pop while repeating"); // R6

  AST_ONE_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (repeatOn && !strobe.frameStart) |=> !evUnderrun) else $error("second underrun"); // R6

  AST_REPEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (repeatOn && strobe.active && $past(repeatOn) && $past(strobe.active)) |=> $stable(pixQ))
    else $error("repeated pixel changed"); // R6

  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.run |=> (!denQ && !hsQ && !vsQ && pixQ == '0)) else $error("active while disabled"); // R1

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import disp_timing_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] hSyncW,
  input  logic [CNT_W-1:0] hBackW,
  input  logic [CNT_W-1:0] hActW,
  input  logic [CNT_W-1:0] hFrontW,
  input  logic [CNT_W-1:0] vSyncW,
  input  logic [CNT_W-1:0] vBackW,
  input  logic [CNT_W-1:0] vActW,
  input  logic [CNT_W-1:0] vFrontW,
  input  logic [4:0]       polarity,
  input  logic             fifoEmpty,
  input  logic [PIX_W-1:0] fifoData,
  output logic             fifoPop,
  output logic             hSyncOut,
  output logic             vSyncOut,
  output logic             dataEnOut,
  output logic [PIX_W-1:0] pixelOut,
  output logic             pxlEdgeSel,
  output logic             evVsyncBegin,
  output logic             evVsyncEnd,
  output logic             evFrameDone,
  output logic             evUnderrun
);

  logic [3:0][CNT_W-1:0] hWidths, vWidths;
  ctl_strobe_t           strobe;

  assign hWidths = {hFrontW, hActW, hBackW, hSyncW};
  assign vWidths = {vFrontW, vActW, vBackW, vSyncW};

  disp_timing_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .hWidths(hWidths), .vWidths(vWidths), .strobe(strobe)
  );

  disp_timing_dp #(.PIX_W(PIX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .polarity(polarity),
    .fifoEmpty(fifoEmpty), .fifoData(fifoData), .fifoPop(fifoPop),
    .hSyncOut(hSyncOut), .vSyncOut(vSyncOut), .dataEnOut(dataEnOut),
    .pixelOut(pixelOut), .pxlEdgeSel(pxlEdgeSel),
    .evVsyncBegin(evVsyncBegin), .evVsyncEnd(evVsyncEnd),
    .evFrameDone(evFrameDone), .evUnderrun(evUnderrun)
  );

endmodule

// File: tb/disp_timing_gen_tb.sv
`timescale 1ns/1ps
module disp_timing_gen_tb;
  localparam int CNT_W = 12;
  localparam int PIX_W = 24;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [CNT_W-1:0] hSyncW = '0, hBackW = '0, hActW = '0, hFrontW = '0;
  logic [CNT_W-1:0] vSyncW = '0, vBackW = '0, vActW = '0, vFrontW = '0;
  logic [4:0] polarity = '0;
  logic fifoEmpty = 1'b1;
  logic [PIX_W-1:0] fifoData = '0;
  logic fifoPop, hSyncOut, vSyncOut, dataEnOut, pxlEdgeSel;
  logic [PIX_W-1:0] pixelOut;
  logic evVsyncBegin, evVsyncEnd, evFrameDone, evUnderrun;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  disp_timing_gen #(.CNT_W(CNT_W), .PIX_W(PIX_W)) u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkIdle();
    check(hSyncOut == polarity[1] && vSyncOut == polarity[0] && dataEnOut == polarity[2],
          "R1 idle sync levels", {hSyncOut, vSyncOut, dataEnOut}, {polarity[1], polarity[0], polarity[2]});
    check(pixelOut == {PIX_W{polarity[3]}} && !pxlEdgeSel, "R1 idle pixel", pixelOut, {PIX_W{polarity[3]}});
    check(!fifoPop && !evVsyncBegin && !evVsyncEnd && !evFrameDone && !evUnderrun,
          "R1 idle events", {fifoPop, evVsyncBegin, evVsyncEnd, evFrameDone, evUnderrun}, 0);
  endtask

  // widths hs hb ha hf vs vb va vf; mode 0 never empty, 1 empties in frame 1, 2 periodic
  task automatic runCfg(input int hs, hb, ha, hf, vs, vb, va, vf,
                        input logic [4:0] pol, input int mode, input int nCyc);
    int L, F, hA0, hA1, vA0, vA1;
    int dataCnt, lastPix, expPix;
    bit ur;
    L = hs + hb + ha + hf + 4; F = vs + vb + va + vf + 4;
    hA0 = hs + hb + 2; hA1 = hA0 + ha;
    vA0 = vs + vb + 2; vA1 = vA0 + va;
    dataCnt = 16'h100; lastPix = 0; ur = 0;
    @(negedge clk);
    enable = 1'b0;
    hSyncW = CNT_W'(hs); hBackW = CNT_W'(hb); hActW = CNT_W'(ha); hFrontW = CNT_W'(hf);
    vSyncW = CNT_W'(vs); vBackW = CNT_W'(vb); vActW = CNT_W'(va); vFrontW = CNT_W'(vf);
    polarity = pol;
    repeat (2) @(negedge clk);
    checkIdle();  // R1 after disabling mid-frame
    enable = 1'b1;
    for (int p = 0; p < nCyc; p++) begin
      int x, y, fr;
      bit act, emp, expPop, expUr;
      x = p % L; y = (p / L) % F; fr = p / (L * F);
      act = (x >= hA0 && x <= hA1 && y >= vA0 && y <= vA1);
      case (mode)
        1: emp = (fr == 1) && (x == hA0 + (ha > 0 ? 1 : 0)) && (y == vA0 || y == vA1);
        2: emp = (p % 7) == 3;
        default: emp = 1'b0;
      endcase
      fifoEmpty = emp;
      fifoData = PIX_W'(dataCnt);
      #1;
      if (x == 0 && y == 0) ur = 0;  // R7 repeat clears at frame start
      expPop = act && !emp && !ur;
      expUr = 0;
      check(fifoPop == expPop, "R5 pop", fifoPop, expPop);
      if (act) begin
        if (expPop) begin
          expPix = dataCnt; lastPix = dataCnt; dataCnt++;
        end else begin
          if (!ur) begin expUr = 1; ur = 1; end
          expPix = lastPix;
        end
      end else expPix = 0;
      @(posedge clk);
      @(negedge clk);
      check(hSyncOut == ((x <= hs) ^ pol[1]), "R2 hsync", hSyncOut, (x <= hs) ^ pol[1]);
      check(vSyncOut == ((y <= vs) ^ pol[0]), "R3 vsync", vSyncOut, (y <= vs) ^ pol[0]);
      check(dataEnOut == (act ^ pol[2]), "R4 data enable", dataEnOut, act ^ pol[2]);
      check(pixelOut == (PIX_W'(expPix) ^ {PIX_W{pol[3]}}), "R6 pixel", pixelOut,
            PIX_W'(expPix) ^ {PIX_W{pol[3]}});
      check(evUnderrun == expUr, "R6 underrun event", evUnderrun, expUr);
      check(evVsyncBegin == (x == 0 && y == 0), "R8 vsync begin", evVsyncBegin, (x == 0 && y == 0));
      check(evVsyncEnd == (x == L - 1 && y == vs), "R8 vsync end", evVsyncEnd, (x == L - 1 && y == vs));
      check(evFrameDone == (x == L - 1 && y == F - 1), "R8 frame done", evFrameDone, (x == L - 1 && y == F - 1));
      check(pxlEdgeSel == pol[4], "R9 pixel clock select", pxlEdgeSel, pol[4]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdle();  // R1 during reset
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle();  // R1 out of reset, disabled
    runCfg(1, 1, 3, 1, 0, 1, 2, 0, 5'b00000, 1, 3 * 70 + 5);
    runCfg(0, 2, 5, 0, 1, 0, 3, 1, 5'b11111, 2, 2 * 120 + 7);
    runCfg(2, 0, 0, 1, 0, 0, 0, 0, 5'b01010, 0, 4 * 28);
    runCfg(0, 0, 1, 0, 0, 0, 1, 0, 5'b10101, 2, 3 * 30);
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    checkIdle();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule